// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block gives on-chip configuration logic single-register access to an external clock-conditioning device over a three-wire serial link: an active-low select, a serial clock and one shared data line. The host presents a direction flag, a 13-bit register address and 8 bits of write data, then pulses `start`. The block serialises a 24-bit frame and reports completion with a one-cycle `done`. For a read, the returned byte is then on `rdata`. A write followed by a read of the same address therefore checks that the device took the value.

The frame goes out most significant bit first. It starts with the direction bit, followed by a pair of zero bits, the address and finally the data byte. For reads the master stops driving the data line after the sixteenth bit and captures the device's byte instead. The shared pin is split into `sdio_o`, `sdio_oe` and `sdio_i`, so the pad ring can build the tri-state buffer. The serial clock is the system clock divided by `CLK_DIV` (even, at least 4).

The controller is a four-state machine:
- `ST_IDLE` moves to `ST_SHIFT` when `start` is accepted.
- `ST_SHIFT` moves to `ST_HOLD` after the last bit period.
- `ST_HOLD` moves to `ST_GAP` after half a serial clock period with select still low.
- `ST_GAP` returns to `ST_IDLE` after `GAP_SCLK` serial clock periods with select high, and pulses `done` as it does so.

Top module: `spi3_reg_master`

## Requirements
- R1: While reset is asserted and after it is released, `cs_n`=1, `sclk`=0, `sdio_oe`=0, `busy`=0, `done`=0 and `rdata`=0.
- R2: The frame is 24 bits, MSB first. Bit 0 is the direction flag (1 = read, 0 = write). Bits 1 and 2 are zero. Bits 3 to 15 are `addr[12:0]`, MSB first. Bits 16 to 23 are `wdata[7:0]`, MSB first.
- R3: `sclk` is low outside a frame. Each bit period lasts `CLK_DIV` cycles: low for the first half and high for the second half. The first rising edge comes `CLK_DIV/2` cycles after `cs_n` falls.
- R4: `sdio_o` changes only at the start of a bit period, while `sclk` is low. It is stable while `sclk` is high.
- R5: `cs_n` falls in the cycle after `start` is accepted. It stays low through all 24 bit periods and for `CLK_DIV/2` cycles after the last falling edge of `sclk`, then goes high.
- R6: During a read, `sdio_oe` is 0 for bit periods 16 to 23. `sdio_i` is captured at each of those rising edges, MSB first, and the byte appears on `rdata` when `done` is high.
- R7: `rdata` keeps the last byte read. A write leaves it unchanged.
- R8: After each frame, `cs_n` stays high for `GAP_SCLK`·`CLK_DIV` cycles (two serial clock periods by default) before `done`.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse with `busy` low. `done` comes 24·`CLK_DIV` + `CLK_DIV/2` + `GAP_SCLK`·`CLK_DIV` + 1 cycles after the accepting edge.
- R10: `start` is ignored while `busy` is high. A `start` in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer; accepted only when not busy |
| rd_nwr | input | 1 | 1 = read, 0 = write; sampled with `start` |
| addr | input | 13 | Register address; sampled with `start` |
| wdata | input | 8 | Write byte; sampled with `start` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read from the device |
| cs_n | output | 1 | Active-low device select |
| sclk | output | 1 | Serial clock, idles low |
| sdio_o | output | 1 | Data toward the device |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdio_i | input | 1 | Data from the shared data pin |

## Verification
Two events can fall in the same cycle: the `done` pulse that ends one frame and the acceptance of the next `start`. The bench holds `start` high through a whole transfer and changes the request fields partway through. It then expects the mid-transfer values to be ignored, and expects the request present at the `done` cycle to begin a new frame one cycle later, with no extra gap. A behavioural model that counts cycles since acceptance predicts select, clock, data, drive enable, busy, done and the read byte on every cycle. The device side of the bench drives 1s outside the read window, so a capture at the wrong edge shows up in `rdata`.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } spi3_state_e;
endpackage

// File: rtl/spi3_phase_gen.sv
// Counts system clocks within one serial clock period and flags the phases.
module spi3_phase_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic high_half,
    output logic last_low,
    output logic at_rise,
    output logic at_end
);
    localparam int CW   = $clog2(CLK_DIV);
    localparam int HALF = CLK_DIV / 2;
    localparam logic [CW-1:0] P_LAST_LOW = CW'(HALF - 1);
    localparam logic [CW-1:0] P_RISE     = CW'(HALF);
    localparam logic [CW-1:0] P_END      = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart || cnt == P_END) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign high_half = (cnt >= P_RISE);
    assign last_low  = (cnt == P_LAST_LOW);
    assign at_rise   = (cnt == P_RISE);
    assign at_end    = (cnt == P_END);
endmodule

// File: rtl/spi3_frame_shifter.sv
// Holds the outgoing frame, counts bit periods and gathers returned bits.
module spi3_frame_shifter #(
    parameter int FRAME_W = 24,
    parameter int RX_W    = 8,
    localparam int IW     = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift,
    input  logic               sample,
    input  logic               sdi,
    output logic               mosi,
    output logic [IW-1:0]      bit_idx,
    output logic [RX_W-1:0]    rx
);
    logic [FRAME_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg    <= '0;
            bit_idx <= '0;
            rx      <= '0;
        end else begin
            if (load) begin
                sreg    <= frame_in;
                bit_idx <= '0;
            end else if (shift) begin
                sreg    <= {sreg[FRAME_W-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
            if (sample) begin
                rx <= {rx[RX_W-2:0], sdi};
            end
        end
    end

    assign mosi = sreg[FRAME_W-1];
endmodule

// File: rtl/spi3_reg_master.sv
module spi3_reg_master
    import spi3_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int GAP_SCLK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdio_o,
    output logic              sdio_oe,
    input  logic              sdio_i
);
    localparam int PAD_W   = 2;
    localparam int CMD_W   = 1 + PAD_W + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int IW      = $clog2(FRAME_W + 1);
    localparam int GW      = $clog2(GAP_SCLK + 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_W - 1);
    localparam logic [IW-1:0] IDX_RX   = IW'(CMD_W);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_SCLK - 1);

    spi3_state_e state, state_n;

    logic          high_half, last_low, at_rise, at_end;
    logic          accept, restart, shift_en, sample_en, mosi, rd_q;
    logic [IW-1:0] bit_idx;
    logic [GW-1:0] gap_cnt;

    assign accept  = (state == ST_IDLE) && start;
    assign restart = (state_n != state);

    spi3_phase_gen #(.CLK_DIV(CLK_DIV)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state != ST_IDLE),
        .restart  (restart),
        .high_half(high_half),
        .last_low (last_low),
        .at_rise  (at_rise),
        .at_end   (at_end)
    );

    assign shift_en  = (state == ST_SHIFT) && at_end;
    assign sample_en = (state == ST_SHIFT) && at_rise && rd_q && (bit_idx >= IDX_RX);

    spi3_frame_shifter #(.FRAME_W(FRAME_W), .RX_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .frame_in({rd_nwr, {PAD_W{1'b0}}, addr, wdata}),
        .shift   (shift_en),
        .sample  (sample_en),
        .sdi     (sdio_i),
        .mosi    (mosi),
        .bit_idx (bit_idx),
        .rx      (rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_SHIFT;
            ST_SHIFT: if (at_end && bit_idx == IDX_LAST) state_n = ST_HOLD;
            ST_HOLD:  if (last_low) state_n = ST_GAP;
            ST_GAP:   if (at_end && gap_cnt == GAP_LAST) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // Side registers: direction, gap periods, completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            gap_cnt <= '0;
            done    <= 1'b0;
        end else begin
            if (accept) rd_q <= rd_nwr;
            if (state != ST_GAP)  gap_cnt <= '0;
            else if (at_end)      gap_cnt <= gap_cnt + 1'b1;
            done <= (state == ST_GAP) && (state_n == ST_IDLE);
        end
    end

    // Output logic
    always_comb begin
        cs_n    = 1'b1;
        sclk    = 1'b0;
        sdio_oe = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_SHIFT: begin
                cs_n    = 1'b0;
                sclk    = high_half;
                sdio_oe = !(rd_q && bit_idx >= IDX_RX);
            end
            ST_HOLD:  cs_n = 1'b0;
            ST_GAP:   cs_n = 1'b1;
            default:  busy = 1'b0;
        endcase
        sdio_o = sdio_oe & mosi;
    end

    // R3: the serial clock toggles only inside a selected frame
    a_r3_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R6: the pin is driven only while the device is selected
    a_r6_drive_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !cs_n);

    // R6: capture never happens while the master still drives the line
    a_r6_capture_released: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> !sdio_oe);

    // R4: data held across the high phase of the serial clock
    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdio_o));

    // R9: done comes with busy dropping
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10: a transfer begins only from a start request
    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/spi3_reg_master_tb_top.sv
module spi3_reg_master_tb_top;
    localparam int D      = 6;
    localparam int H      = D / 2;
    localparam int GAP    = 2;
    localparam int FW     = 24;
    localparam int CMDW   = 16;
    localparam int SH_END = FW * D;
    localparam int HO_END = SH_END + H;
    localparam int DONE_T = HO_END + GAP * D + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        sdio_i = 1'b1;
    logic        busy, done, cs_n, sclk, sdio_o, sdio_oe;
    logic [7:0]  rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // model state
    int          t = -1;
    logic        m_rd = 1'b0;
    logic [23:0] m_frame = '0;
    logic [7:0]  m_rval = '0;
    logic [7:0]  m_rdata_exp = '0;
    logic [7:0]  dev_val = '0;

    always #10 clk = ~clk;

    spi3_reg_master #(.CLK_DIV(D), .GAP_SCLK(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .cs_n(cs_n),
        .sclk(sclk), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Reference model: cycles since the accepting edge
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
        if (!rst_n) begin
            t = -1;
        end else begin
            if (((t < 0) || (t == DONE_T)) && start) begin
                t       = 1;
                m_rd    = rd_nwr;
                m_frame = {rd_nwr, 2'b00, addr, wdata};
                m_rval  = dev_val;
                if (rd_nwr) m_rdata_exp = dev_val;
            end else if ((t < 0) || (t == DONE_T)) begin
                t = -1;
            end else begin
                t = t + 1;
            end
        end
    end

    // Compare on every clock, away from the active edge; then act as the device
    always @(negedge clk) begin
        int k, p;
        logic e_oe, e_do;
        string tg;
        tg = rst_n ? "R5" : "R1";
        if (t < 0 || t == DONE_T) begin
            chk(tg, cs_n, 1'b1);
            chk(rst_n ? "R3" : "R1", sclk, 1'b0);
            chk(rst_n ? "R6" : "R1", sdio_oe, 1'b0);
            chk(rst_n ? "R9" : "R1", busy, 1'b0);
            chk(rst_n ? "R9" : "R1", done, (t == DONE_T));
            chk(rst_n ? "R7" : "R1", rdata, m_rdata_exp);
            sdio_i <= 1'b1;
        end else if (t <= SH_END) begin
            k = (t - 1) / D;
            p = (t - 1) % D;
            e_oe = !(m_rd && k >= CMDW);
            e_do = e_oe ? m_frame[FW-1-k] : 1'b0;
            chk("R5", cs_n, 1'b0);
            chk("R3", sclk, (p >= H));
            chk("R6", sdio_oe, e_oe);
            chk("R2", sdio_o, e_do);
            chk(start ? "R10" : "R9", busy, 1'b1);
            chk("R9", done, 1'b0);
            sdio_i <= (m_rd && k >= CMDW) ? m_rval[7-(k-CMDW)] : 1'b1;
        end else if (t <= HO_END) begin
            chk("R5", cs_n, 1'b0);
            chk("R3", sclk, 1'b0);
            chk("R6", sdio_oe, 1'b0);
            chk("R9", busy, 1'b1);
            sdio_i <= 1'b1;
        end else begin
            chk("R8", cs_n, 1'b1);
            chk("R3", sclk, 1'b0);
            chk("R9", busy, 1'b1);
            chk("R9", done, 1'b0);
            sdio_i <= 1'b1;
        end
    end

    task automatic wait_done();
        do @(negedge clk); while (done !== 1'b1);
    endtask

    task automatic xfer(input logic rd, input logic [12:0] a, input logic [7:0] wd,
                        input logic [7:0] dv);
        @(negedge clk);
        rd_nwr  <= rd;
        addr    <= a;
        wdata   <= wd;
        dev_val <= dv;
        start   <= 1'b1;
        @(negedge clk);
        start <= 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        repeat (3) @(negedge clk);
        // R2 write frame, R7 rdata stays 0
        xfer(1'b0, 13'h00A5, 8'h3C, 8'h00);
        // R6 reads with alternating device bytes
        xfer(1'b1, 13'h1FFF, 8'h00, 8'hA5);
        xfer(1'b1, 13'h0000, 8'hFF, 8'h5A);
        // R7 write of all ones must keep 5A
        xfer(1'b0, 13'h1FFF, 8'hFF, 8'h00);
        // R10 start during busy is ignored
        @(negedge clk);
        rd_nwr <= 1'b0; addr <= 13'h0123; wdata <= 8'h81; start <= 1'b1;
        @(negedge clk);
        start <= 1'b0;
        repeat (40) @(negedge clk);
        rd_nwr <= 1'b1; addr <= 13'h1555; dev_val <= 8'h99; start <= 1'b1;
        @(negedge clk);
        start <= 1'b0;
        wait_done();
        // R10 start held through a transfer, next request accepted at done
        @(negedge clk);
        rd_nwr <= 1'b0; addr <= 13'h0155; wdata <= 8'h0F; start <= 1'b1;
        repeat (30) @(negedge clk);
        rd_nwr <= 1'b1; addr <= 13'h00AA; dev_val <= 8'hC3;
        wait_done();
        @(negedge clk);
        start <= 1'b0;
        wait_done();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule